// File: doc/BRIEF.md
# LFSR Memory Self-Test with Signature Analyzer

This block runs an offline self-test over a small bit-oriented memory. After a start pulse it walks a linear feedback shift register through the memory's address space, one address per clock. It takes the single read bit for that address in the same cycle, since the read is combinational. Each bit is shifted into a serial signature register. When the last cell has been read, a one-cycle done pulse marks the end of the run. The final signature is then held on the output and compared with an expected value supplied by the caller.

The address register steps by multiplying its state by X modulo a primitive polynomial of degree K. The signature register uses the reciprocal of that polynomial. With this pairing the final signature is the XOR of the bit-reversed addresses of every cell that read as one. A single faulty cell can therefore be located straight from the difference between the expected and the measured signatures, and a wrong multi-cell pattern goes unnoticed with a probability of roughly 2^-K. When the memory has fewer than 2^K-1 cells, the address register is seeded so that the walk still finishes on the same final address.

Top module: `mbist_lfsr_sig`

## Requirements
- R1: After reset, busy, done, pass and fail are 0 and the signature output is 0.
- R2: Addresses follow s_next = s·X mod P, where bit j of parameter POLY is the coefficient of X^j. The first address of a run is X^(2^K-1-NUM_CELLS), which is 1 for a full-size memory. One new address is presented in each busy cycle, and a run visits NUM_CELLS distinct nonzero addresses.
- R3: The last address read in every run is X^-1 mod P. For K=3 and P=1+X+X^3 this is 3'b101.
- R4: A start pulse while idle raises busy on the next clock edge. Busy stays high for exactly NUM_CELLS cycles, and done is high for exactly one cycle, in the cycle after the last busy cycle.
- R5: The signature register uses the reciprocal polynomial X^K·P(1/X) as its feedback and is cleared to zero when a run starts.
- R6: The final signature equals the XOR, over all cells that read as 1, of the cell address with its bits reversed (address bit i goes to signature bit K-1-i). A memory that holds only zeros gives 0.
- R7: With K=3, if only one cell holds a 1 the signature is that address reversed; address 3'b110 gives 3'b011.
- R8: In the done cycle, fail is 1 if the final signature differs from exp_sig_i (sampled in the last busy cycle) and pass is 1 otherwise. Both flags hold until the next run starts and are 0 from the first busy cycle of that run.
- R9: A start pulse during a run has no effect: run length, addresses and signature are unchanged.
- R10: With a memory of fewer than 2^K-1 cells (K=4, P=1+X+X^4, 11 cells) the first address is 4'b0011, the last is 4'b1001, and the signature follows R6 over the visited cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| busy_o | output | 1 | High while cells are being read |
| done_o | output | 1 | One-cycle pulse after the last cell |
| addr_o | output | K | Address of the cell being read |
| rd_data_i | input | 1 | Combinational read bit for addr_o |
| exp_sig_i | input | K | Expected signature |
| sig_o | output | K | Running and final signature |
| pass_o | output | 1 | Final signature matched |
| fail_o | output | 1 | Final signature differed |

## Verification
Two corner cases target the feedback wiring. A single one in the final cell read exposes a wrong injection point in the signature register, which would give a constant other than 3'b101. An all-ones memory must cancel to zero, and a wrong reciprocal tap would leave a nonzero residue. A start pulse partway through a run checks that the run does not restart, which would lengthen busy and scramble the signature. An 11-cell instance checks the seed: a design seeded at 1 would end on the wrong address. The pass and fail flags are checked to hold after done and to clear at the next run, so that a stale verdict cannot go unnoticed.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int MAX_W = 32;
    typedef logic [MAX_W-1:0] wide_t;

    // Reciprocal polynomial: coefficient j becomes coefficient k-j
    function automatic wide_t reciprocal(input wide_t poly, input int k);
        wide_t r;
        r = '0;
        for (int j = 0; j <= k; j++) begin
            r[j] = poly[k-j];
        end
        return r;
    endfunction

    // Multiply state by X modulo poly (Galois step)
    function automatic wide_t gal_step(input wide_t s, input wide_t poly, input int k);
        wide_t msk;
        wide_t nxt;
        msk = (wide_t'(1) << k) - wide_t'(1);
        nxt = (s << 1) & msk;
        if (s[k-1]) begin
            nxt = nxt ^ (poly & msk);
        end
        return nxt;
    endfunction

    // Seed so that a run of n cells ends at X^-1: X^(2^k-1-n)
    function automatic wide_t seed_state(input wide_t poly, input int k, input int n);
        wide_t s;
        s = wide_t'(1);
        for (int i = 0; i < ((1 << k) - 1 - n); i++) begin
            s = gal_step(s, poly, k);
        end
        return s;
    endfunction

endpackage

// File: rtl/mbist_addr_lfsr.sv
module mbist_addr_lfsr #(
    parameter int K = 3,
    parameter logic [K:0] POLY = 4'b1011,
    parameter logic [K-1:0] SEED = 3'b001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    output logic [K-1:0] addr_o
);

    logic [K-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load_i) begin
            addr_d = SEED;
        end else if (step_i) begin
            addr_d = {addr_q[K-2:0], 1'b0} ^ (addr_q[K-1] ? POLY[K-1:0] : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= SEED;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    assert_addr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q != '0);

    assert_addr_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (addr_q != $past(addr_q)));

endmodule

// File: rtl/mbist_sig_lfsr.sv
module mbist_sig_lfsr #(
    parameter int K = 3,
    parameter logic [K:0] RPOLY = 4'b1101
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [K-1:0] sig_o,
    output logic [K-1:0] sig_next_o
);

    logic [K-1:0] sig_d, sig_q;
    logic         fb;
    logic [K-1:0] shifted;

    always_comb begin
        fb      = sig_q[K-1] ^ bit_i;
        shifted = {sig_q[K-2:0], 1'b0} ^ (fb ? RPOLY[K-1:0] : '0);
        sig_d   = sig_q;
        if (clear_i)      sig_d = '0;
        else if (shift_i) sig_d = shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig_o      = sig_q;
    assign sig_next_o = shifted;

    assert_sig_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (sig_q == '0));

    assert_sig_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !shift_i) |=> (sig_q == $past(sig_q)));

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq #(
    parameter int NUM_CELLS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic load_o,
    output logic last_o
);

    localparam int CW = (NUM_CELLS > 2) ? $clog2(NUM_CELLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(NUM_CELLS - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (!seq_q.busy) begin
            if (start_i) begin
                seq_d.busy = 1'b1;
                seq_d.cnt  = '0;
            end
        end else if (seq_q.cnt == LAST) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
        end else begin
            seq_d.cnt = seq_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign done_o = seq_q.done;
    assign load_o = start_i && !seq_q.busy;
    assign last_o = seq_q.busy && (seq_q.cnt == LAST);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(last_o));

    assert_not_busy_and_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_cnt_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> (busy_o && seq_q.cnt == $past(seq_q.cnt) + CW'(1)));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !last_o) |=> busy_o);

endmodule

// File: rtl/mbist_lfsr_sig.sv
module mbist_lfsr_sig #(
    parameter int K = 3,
    parameter logic [K:0] POLY = 4'b1011,
    parameter int NUM_CELLS = (1 << K) - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [K-1:0] addr_o,
    input  logic         rd_data_i,
    input  logic [K-1:0] exp_sig_i,
    output logic [K-1:0] sig_o,
    output logic         pass_o,
    output logic         fail_o
);

    import mbist_pkg::*;

    localparam wide_t POLY_W  = wide_t'(POLY);
    localparam wide_t RPOLY_W = reciprocal(POLY_W, K);
    localparam wide_t SEED_W  = seed_state(POLY_W, K, NUM_CELLS);
    localparam logic [K:0]   RPOLY = RPOLY_W[K:0];
    localparam logic [K-1:0] SEED  = SEED_W[K-1:0];

    typedef struct packed {
        logic pass;
        logic fail;
    } verdict_t;

    logic         load, last, busy;
    logic [K-1:0] sig_next;
    verdict_t     vd_d, vd_q;

    mbist_seq #(.NUM_CELLS(NUM_CELLS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .busy_o (busy),
        .done_o (done_o),
        .load_o (load),
        .last_o (last)
    );

    mbist_addr_lfsr #(.K(K), .POLY(POLY), .SEED(SEED)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .step_i(busy),
        .addr_o(addr_o)
    );

    mbist_sig_lfsr #(.K(K), .RPOLY(RPOLY)) u_sig (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (load),
        .shift_i   (busy),
        .bit_i     (rd_data_i),
        .sig_o     (sig_o),
        .sig_next_o(sig_next)
    );

    always_comb begin
        vd_d = vd_q;
        if (load) begin
            vd_d = '0;
        end else if (last) begin
            vd_d.fail = (sig_next != exp_sig_i);
            vd_d.pass = (sig_next == exp_sig_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= '0;
        else        vd_q <= vd_d;
    end

    assign busy_o = busy;
    assign pass_o = vd_q.pass;
    assign fail_o = vd_q.fail;

    assert_verdict_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));

    assert_verdict_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o || fail_o));

    assert_verdict_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!pass_o && !fail_o));

endmodule

// File: tb/tb_mbist_lfsr_sig.sv
module tb_mbist_lfsr_sig;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;

    // K=3 full-size instance
    logic       start3 = 1'b0;
    logic [2:0] exp3 = '0;
    logic       busy3, done3, rd3, pass3, fail3;
    logic [2:0] addr3, sig3;
    logic       mem3 [8];

    // K=4, 11-cell instance
    logic       start4 = 1'b0;
    logic [3:0] exp4 = '0;
    logic       busy4, done4, rd4, pass4, fail4;
    logic [3:0] addr4, sig4;
    logic       mem4 [16];

    assign rd3 = mem3[addr3];
    assign rd4 = mem4[addr4];

    mbist_lfsr_sig dut (
        .clk(clk), .rst_n(rst_n), .start_i(start3), .busy_o(busy3), .done_o(done3),
        .addr_o(addr3), .rd_data_i(rd3), .exp_sig_i(exp3), .sig_o(sig3),
        .pass_o(pass3), .fail_o(fail3)
    );

    mbist_lfsr_sig #(.K(4), .POLY(5'b10011), .NUM_CELLS(11)) dut_short (
        .clk(clk), .rst_n(rst_n), .start_i(start4), .busy_o(busy4), .done_o(done4),
        .addr_o(addr4), .rd_data_i(rd4), .exp_sig_i(exp4), .sig_o(sig4),
        .pass_o(pass4), .fail_o(fail4)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] rev3(input logic [2:0] a);
        return {a[0], a[1], a[2]};
    endfunction

    function automatic logic [3:0] rev4(input logic [3:0] a);
        return {a[0], a[1], a[2], a[3]};
    endfunction

    // R6: expected signature for the full-size memory
    function automatic logic [2:0] model3();
        logic [2:0] s = '0;
        for (int a = 1; a < 8; a++) if (mem3[a]) s ^= rev3(3'(a));
        return s;
    endfunction

    // R10: visited cells are X^4 .. X^14 mod 1+X+X^4
    function automatic logic [3:0] model4();
        logic [3:0] s = '0;
        logic [3:0] a = 4'b0011;
        for (int i = 0; i < 11; i++) begin
            if (mem4[a]) s ^= rev4(a);
            a = {a[2:0], 1'b0} ^ (a[3] ? 4'b0011 : 4'b0000);
        end
        return s;
    endfunction

    // Scoreboard for the K=3 instance
    typedef struct {
        logic [2:0] sig;
        logic       fail;
    } item_t;
    item_t sb_q[$];

    int         mon_cycles = 0;
    logic [2:0] mon_first, mon_last;
    logic [7:0] mon_seen = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy3) begin
                if (mon_cycles == 0) mon_first = addr3;
                mon_last = addr3;
                mon_seen[addr3] = 1'b1;
                mon_cycles++;
            end
            if (done3) begin
                item_t it;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4 unexpected done", 1, 0);
                end else begin
                    it = sb_q.pop_front();
                    check(sig3 == it.sig, "R6 signature", sig3, it.sig);
                    check(fail3 == it.fail && pass3 == !it.fail, "R8 verdict",
                          {pass3, fail3}, {!it.fail, it.fail});
                end
                check(mon_cycles == 7, "R4 busy length", mon_cycles, 7);
                check($countones(mon_seen) == 7 && !mon_seen[0], "R2 distinct addresses",
                      $countones(mon_seen), 7);
                check(mon_first == 3'b001, "R2 first address", mon_first, 1);
                check(mon_last == 3'b101, "R3 last address", mon_last, 5);
                mon_cycles = 0;
                mon_seen   = '0;
            end
        end
    end

    // Driver: push expectation, pulse start, optionally poke start mid-run (R9)
    task automatic run3(input logic [2:0] expected_in, input bit poke);
        item_t it;
        exp3    = expected_in;
        it.sig  = model3();
        it.fail = (it.sig != expected_in);
        sb_q.push_back(it);
        @(negedge clk) start3 = 1'b1;
        @(negedge clk) start3 = 1'b0;
        check(busy3 && !pass3 && !fail3 && sig3 == 3'b000, "R8 flags cleared at start",
              {busy3, pass3, fail3}, 3'b100);
        if (poke) begin
            repeat (2) @(negedge clk);
            start3 = 1'b1;
            @(negedge clk) start3 = 1'b0;
        end
        while (!done3) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run4(input logic [3:0] expected_in);
        int         cyc = 0;
        logic [3:0] first = '0, last = '0, want;
        want = model4();
        exp4 = expected_in;
        @(negedge clk) start4 = 1'b1;
        @(negedge clk) start4 = 1'b0;
        while (!done4) begin
            if (busy4) begin
                if (cyc == 0) first = addr4;
                last = addr4;
                cyc++;
            end
            @(negedge clk);
        end
        check(cyc == 11, "R10 busy length", cyc, 11);
        check(first == 4'b0011, "R10 first address", first, 3);
        check(last == 4'b1001, "R10 last address", last, 9);
        check(sig4 == want, "R10 signature", sig4, want);
        check(pass4 == (want == expected_in) && fail4 == (want != expected_in),
              "R10 verdict", {pass4, fail4}, {want == expected_in, want != expected_in});
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < 8; a++) mem3[a] = 1'b0;
        for (int a = 0; a < 16; a++) mem4[a] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy3 && !done3 && !pass3 && !fail3 && sig3 == '0, "R1 reset K3",
              {busy3, done3, pass3, fail3}, 0);
        check(!busy4 && !done4 && !pass4 && !fail4 && sig4 == '0, "R1 reset K4",
              {busy4, done4, pass4, fail4}, 0);

        // R6: all zeros -> 0, pass
        run3(3'b000, 1'b0);

        // R7: single one at 3'b110 -> 3'b011
        mem3[6] = 1'b1;
        check(model3() == 3'b011, "R7 model value", model3(), 3);
        run3(3'b011, 1'b0);
        // R8: verdict held after done
        repeat (3) @(negedge clk);
        check(pass3 && !fail3 && sig3 == 3'b011, "R8 verdict held", {pass3, fail3}, 2);

        // R5/R6: single one at the final address -> 3'b101
        mem3[6] = 1'b0;
        mem3[5] = 1'b1;
        run3(3'b101, 1'b0);

        // R6: mixed pattern
        mem3[5] = 1'b0;
        mem3[1] = 1'b1; mem3[2] = 1'b1; mem3[7] = 1'b1;
        run3(3'b001, 1'b0);

        // R6/R8: all ones cancel to 0, mismatching expectation -> fail
        for (int a = 1; a < 8; a++) mem3[a] = 1'b1;
        run3(3'b010, 1'b0);

        // R9: start pulse during a run is ignored
        for (int a = 1; a < 8; a++) mem3[a] = (a % 3 == 0);
        run3(model3(), 1'b1);

        // R10: short memory
        for (int a = 0; a < 16; a++) mem4[a] = 1'b1;
        run4(model4());
        for (int a = 0; a < 16; a++) mem4[a] = (a == 3) || (a == 9) || (a == 12);
        run4(4'b1111);

        check(sb_q.size() == 0, "R4 all runs completed", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule